// File: doc/BRIEF.md
# HDLC Frame Transmitter with Byte FIFO

This block takes bytes from a host into a 64-entry transmit queue and sends them on a serial line as HDLC frames. Each queued byte carries a marker bit that the host raises together with the last byte of a message. That marked byte closes the frame. The serialiser follows the byte with a 16-bit frame check sequence and then a flag. While nothing is queued, the line carries back-to-back flags. A frame begins at the first flag boundary after a byte arrives in the queue.

The serial line advances only on cycles where an external bit-enable strobe is high. This lets the block feed a slot in a larger framing structure. Inside data and check bits, a zero is inserted after any five consecutive ones. The host paces itself by reading the queue status: empty, full, not full and at least half full. Two sticky events are latched: message sent and underrun. Both are cleared by a single clear input. One interrupt line combines three maskable sources. If the queue runs dry inside a frame, the block aborts the frame with a run of ones and sets the underrun event.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After reset: st_empty=1, st_full=0, st_not_full=1, st_half=0, st_underrun=0, st_msg_end=0, irq=0 and tx_bit=1.
- R2: With the queue empty, the line carries continuous flags 0x7E, sent LSB first (bit sequence 0,1,1,1,1,1,1,0). No flag is ever stuffed.
- R3: The queue holds 64 bytes. st_full=1 exactly when 64 bytes are held, and st_not_full is its complement. A write while st_full=1 is ignored.
- R4: st_half=1 exactly when 32 or more bytes are held.
- R5: A frame consists of an opening flag, the queued bytes in write order (each sent LSB first), the check sequence and a closing flag. The byte written with wr_last=1 is the final data byte. Frames queued back to back are sent back to back, one flag apart.
- R6: The check sequence is CRC-16 over the data bits, using the reflected polynomial 0x8408 and preset 0xFFFF. It is complemented and sent LSB first. A receiver running the same CRC over data plus check sequence ends on the residue 0xF0B8.
- R7: After five consecutive ones in data or check-sequence bits, a 0 is inserted. A frame made only of 0xFF bytes is therefore received intact.
- R8: If the queue is empty at a byte boundary inside a frame (the last byte sent had wr_last=0), st_underrun is set. The line then sends at least seven consecutive ones, followed by flags. No valid frame is produced.
- R9: st_msg_end is set once the last check-sequence bit of a frame has been sent. st_msg_end and st_underrun stay set until a cycle with evt_clr=1, which clears both.
- R10: irq = (ie_half & ~st_half) | (ie_nf & st_not_full) | (ie_end & st_msg_end).
- R11: tx_bit changes only on the clock edge that samples bit_en=1. Each such edge sends exactly one line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks this byte as the end of its message |
| bit_en | input | 1 | Line bit strobe: one bit is sent per high cycle |
| ie_half | input | 1 | Interrupt enable for the below-half source |
| ie_nf | input | 1 | Interrupt enable for the not-full source |
| ie_end | input | 1 | Interrupt enable for the message-sent event |
| evt_clr | input | 1 | Clears the sticky message-sent and underrun events |
| tx_bit | output | 1 | Serial line output |
| st_empty | output | 1 | Queue holds no bytes |
| st_full | output | 1 | Queue holds 64 bytes |
| st_not_full | output | 1 | Queue can accept a byte |
| st_half | output | 1 | Queue holds at least 32 bytes |
| st_underrun | output | 1 | Sticky: a frame was aborted because the queue ran dry |
| st_msg_end | output | 1 | Sticky: a frame finished sending |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench decodes the line with its own receiver. The receiver removes stuffed zeros, finds flags and aborts, and checks each frame's bytes and CRC residue. Frames of all-ones bytes and of flag-valued bytes are sent under steady, sparse and irregular strobes. A design without stuffing, or one that stuffed its flags, would break these frames or lose idle flags. The queue is filled to exactly 31, 32, 63 and 64 bytes with the line stalled, followed by one extra write. A wrong threshold or an accepted overflow write shows up in the status bits or as a 65-byte frame. A message left without its end marker must give an abort, an underrun flag and no frame. A design that closed the frame normally, or stalled, would fail this test.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W = 8;
    localparam int FCS_W = 16;
    localparam int CNT_W = 4;
    localparam int RUN_W = 3;
    localparam int STUFF_RUN = 5;
    localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;
    localparam logic [FCS_W-1:0] CRC_PRESET = 16'hFFFF;
    localparam logic [FCS_W-1:0] CRC_POLY_REFL = 16'h8408;

    typedef enum logic [1:0] {
        PH_FLAG,
        PH_DATA,
        PH_FCS,
        PH_ABORT
    } tx_phase_e;

    typedef struct packed {
        tx_phase_e          phase;
        logic [FCS_W-1:0]   shreg;
        logic [CNT_W-1:0]   cnt;
        logic [RUN_W-1:0]   ones;
        logic [FCS_W-1:0]   crc;
        logic               last;
        logic               tx;
    } ser_reg_t;

    typedef struct packed {
        logic urun;
        logic mend;
    } evt_reg_t;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = 16'h8408
) (
    input  logic [W-1:0] crc_in,
    input  logic         bit_in,
    output logic [W-1:0] crc_out
);
    logic fb;

    always_comb begin
        fb = crc_in[0] ^ bit_in;
        for (int i = 0; i < W; i++) begin
            if (i == W - 1) begin
                crc_out[i] = fb & POLY[i];
            end else begin
                crc_out[i] = crc_in[i+1] ^ (fb & POLY[i]);
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int DW = 9,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] fill
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        p_d     = p_q;
        push_ok = push_req && (p_q.cnt != CW'(DEPTH));
        pop_ok  = pop && (p_q.cnt != '0);
        if (push_ok) p_d.wp = adv(p_q.wp);
        if (pop_ok)  p_d.rp = adv(p_q.rp);
        case ({push_ok, pop_ok})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[p_q.wp] <= push_data;
    end

    assign head = mem_q[p_q.rp];
    assign fill = p_q.cnt;
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
    import hdlc_tx_pkg::*;
#(
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          src_empty,
    input  logic [BW-1:0] src_data,
    input  logic          src_last,
    output logic          src_pop,
    output logic          tx_bit,
    output logic          frame_done,
    output logic          underrun_evt
);
    ser_reg_t r_d, r_q;
    logic [FCS_W-1:0] crc_step;
    logic cur_bit;

    hdlc_tx_crc #(.W(FCS_W), .POLY(CRC_POLY_REFL)) u_crc (
        .crc_in (r_q.crc),
        .bit_in (r_q.shreg[0]),
        .crc_out(crc_step)
    );

    always_comb begin
        r_d          = r_q;
        src_pop      = 1'b0;
        frame_done   = 1'b0;
        underrun_evt = 1'b0;
        cur_bit      = r_q.shreg[0];
        if (bit_en) begin
            if (r_q.ones == RUN_W'(STUFF_RUN)) begin
                // stuffed zero: no phase advance
                r_d.tx   = 1'b0;
                r_d.ones = '0;
            end else begin
                case (r_q.phase)
                    PH_FLAG: begin
                        r_d.tx   = FLAG_PAT[r_q.cnt[2:0]];
                        r_d.ones = '0;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(BW - 1)) begin
                            r_d.cnt = '0;
                            if (!src_empty) begin
                                src_pop   = 1'b1;
                                r_d.phase = PH_DATA;
                                r_d.shreg = {{(FCS_W-BW){1'b0}}, src_data};
                                r_d.last  = src_last;
                                r_d.crc   = CRC_PRESET;
                            end
                        end
                    end
                    PH_DATA: begin
                        r_d.tx    = cur_bit;
                        r_d.ones  = cur_bit ? r_q.ones + 1'b1 : '0;
                        r_d.crc   = crc_step;
                        r_d.shreg = r_q.shreg >> 1;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(BW - 1)) begin
                            r_d.cnt = '0;
                            if (r_q.last) begin
                                r_d.phase = PH_FCS;
                                r_d.shreg = ~crc_step;
                            end else if (!src_empty) begin
                                src_pop   = 1'b1;
                                r_d.shreg = {{(FCS_W-BW){1'b0}}, src_data};
                                r_d.last  = src_last;
                            end else begin
                                r_d.phase    = PH_ABORT;
                                underrun_evt = 1'b1;
                            end
                        end
                    end
                    PH_FCS: begin
                        r_d.tx    = cur_bit;
                        r_d.ones  = cur_bit ? r_q.ones + 1'b1 : '0;
                        r_d.shreg = r_q.shreg >> 1;
                        r_d.cnt   = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(FCS_W - 1)) begin
                            r_d.cnt    = '0;
                            r_d.phase  = PH_FLAG;
                            frame_done = 1'b1;
                        end
                    end
                    default: begin
                        r_d.tx   = 1'b1;
                        r_d.ones = '0;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == CNT_W'(BW - 1)) begin
                            r_d.cnt   = '0;
                            r_d.phase = PH_FLAG;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{phase: PH_FLAG, shreg: '0, cnt: '0, ones: '0,
                     crc: CRC_PRESET, last: 1'b0, tx: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_bit = r_q.tx;
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              bit_en,
    input  logic              ie_half,
    input  logic              ie_nf,
    input  logic              ie_end,
    input  logic              evt_clr,
    output logic              tx_bit,
    output logic              st_empty,
    output logic              st_full,
    output logic              st_not_full,
    output logic              st_half,
    output logic              st_underrun,
    output logic              st_msg_end,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = BYTE_W + 1;

    logic [CW-1:0] fill_cnt;
    logic [EW-1:0] fifo_head;
    logic ser_pop, ser_done, ser_urun;
    evt_reg_t e_d, e_q;

    hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(EW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .push_data({wr_last, wr_data}),
        .pop      (ser_pop),
        .head     (fifo_head),
        .fill     (fill_cnt)
    );

    hdlc_tx_ser #(.BW(BYTE_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .src_empty   (st_empty),
        .src_data    (fifo_head[BYTE_W-1:0]),
        .src_last    (fifo_head[BYTE_W]),
        .src_pop     (ser_pop),
        .tx_bit      (tx_bit),
        .frame_done  (ser_done),
        .underrun_evt(ser_urun)
    );

    always_comb begin
        e_d = e_q;
        if (evt_clr) begin
            e_d.urun = 1'b0;
            e_d.mend = 1'b0;
        end
        if (ser_done) e_d.mend = 1'b1;
        if (ser_urun) e_d.urun = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign st_empty    = (fill_cnt == '0);
    assign st_full     = (fill_cnt == CW'(DEPTH));
    assign st_not_full = ~st_full;
    assign st_half     = (fill_cnt >= CW'(DEPTH / 2));
    assign st_underrun = e_q.urun;
    assign st_msg_end  = e_q.mend;
    assign irq = (ie_half & ~st_half) | (ie_nf & st_not_full) | (ie_end & e_q.mend);
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bit_en,
    input logic          tx_bit,
    input logic          st_underrun,
    input logic          st_msg_end,
    input logic          evt_clr,
    input logic          ie_half,
    input logic          ie_nf,
    input logic          ie_end,
    input logic          irq,
    input logic [CW-1:0] fill_cnt
);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fill_cnt == $past(fill_cnt)) || (fill_cnt == $past(fill_cnt) + 1'b1)
                 || (fill_cnt + 1'b1 == $past(fill_cnt)));

    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));

    p_urun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_underrun && !evt_clr) |=> st_underrun);

    p_mend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_msg_end && !evt_clr) |=> st_msg_end);

    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_half && !ie_nf && !ie_end) |-> !irq);
endmodule

bind hdlc_frame_tx hdlc_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_bit     (tx_bit),
    .st_underrun(st_underrun),
    .st_msg_end (st_msg_end),
    .evt_clr    (evt_clr),
    .ie_half    (ie_half),
    .ie_nf      (ie_nf),
    .ie_end     (ie_end),
    .irq        (irq),
    .fill_cnt   (fill_cnt)
);

// File: tb/sim_hdlc_frame_tx.sv
module sim_hdlc_frame_tx;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, wr_en = 1'b0, wr_last = 1'b0, bit_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic ie_half = 1'b0, ie_nf = 1'b0, ie_end = 1'b0, evt_clr = 1'b0;
    logic tx_bit, st_empty, st_full, st_not_full, st_half, st_underrun, st_msg_end, irq;

    hdlc_frame_tx #(.DEPTH(64)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .bit_en(bit_en), .ie_half(ie_half), .ie_nf(ie_nf), .ie_end(ie_end),
        .evt_clr(evt_clr), .tx_bit(tx_bit), .st_empty(st_empty), .st_full(st_full),
        .st_not_full(st_not_full), .st_half(st_half), .st_underrun(st_underrun),
        .st_msg_end(st_msg_end), .irq(irq)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bit strobe generator
    int en_mode = 0;
    int ph = 0;
    logic [7:0] lf = 8'h5A;
    always @(negedge clk) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        ph = (ph == 2) ? 0 : ph + 1;
        case (en_mode)
            1:       bit_en = 1'b1;
            2:       bit_en = (ph == 0);
            3:       bit_en = lf[0];
            default: bit_en = 1'b0;
        endcase
    end

    logic en_d = 1'b0;
    always @(posedge clk) en_d <= bit_en && rst_n;

    // expected frames
    logic [7:0] exp_mem [0:4095];
    int exp_start [0:127];
    int exp_len [0:127];
    int exp_n = 0;
    int exp_top = 0;
    bit rx_good [0:127];

    // line receiver
    bit rbits [0:4095];
    int nb = 0;
    int ones = 0;
    int rx_idx = 0;
    int idle_flags = 0;
    int aborts = 0;
    int tx_viol = 0;
    logic prev_tx = 1'b1;

    task automatic handle_frame();
        int nbytes, dlen, mism, el, es;
        logic [15:0] c;
        logic [7:0] v;
        bit ok;
        nbytes = nb / 8;
        ok = 1'b1;
        if ((nb % 8) != 0 || nbytes < 3 || rx_idx >= exp_n) begin
            chk(1'b0, "R5", nb, (rx_idx < exp_n) ? (exp_len[rx_idx] + 2) * 8 : 0);
            ok = 1'b0;
        end else begin
            c = 16'hFFFF;
            for (int i = 0; i < nb; i++) begin
                c = (c >> 1) ^ (((c[0] ^ rbits[i]) == 1'b1) ? 16'h8408 : 16'h0000);
            end
            chk(c == 16'hF0B8, "R6", int'(c), 32'hF0B8);
            if (c != 16'hF0B8) ok = 1'b0;
            dlen = nbytes - 2;
            el = exp_len[rx_idx];
            es = exp_start[rx_idx];
            chk(dlen == el, "R5", dlen, el);
            if (dlen != el) ok = 1'b0;
            mism = 0;
            for (int i = 0; i < dlen && i < el; i++) begin
                for (int j = 0; j < 8; j++) v[j] = rbits[i*8+j];
                if (v != exp_mem[es+i]) mism++;
            end
            chk(mism == 0, "R5", mism, 0);
            if (mism != 0) ok = 1'b0;
        end
        if (rx_idx < 128) rx_good[rx_idx] = ok;
        rx_idx++;
    endtask

    task automatic rx_bit(input logic b);
        if (b) begin
            ones++;
            if (ones >= 7) begin
                if (ones == 7) aborts++;
                nb = 0;
            end else if (nb < 4096) begin
                rbits[nb] = 1'b1;
                nb++;
            end
        end else begin
            if (ones == 5) begin
                ones = 0;
            end else if (ones == 6) begin
                ones = 0;
                nb = (nb >= 7) ? nb - 7 : 0;
                if (nb == 0) idle_flags++;
                else handle_frame();
                nb = 0;
            end else begin
                ones = 0;
                if (nb < 4096) begin
                    rbits[nb] = 1'b0;
                    nb++;
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (en_d) rx_bit(tx_bit);
            else if (tx_bit !== prev_tx) tx_viol++;
        end
        prev_tx = tx_bit;
    end

    function automatic logic [7:0] gen(input int kind, input int i);
        case (kind)
            0:       return 8'hFF;
            1:       return 8'h7E;
            2:       return 8'(i * 37 + 5);
            3:       return 8'h00;
            default: return 8'(i) ^ 8'hA5;
        endcase
    endfunction

    task automatic write_byte(input logic [7:0] b, input logic l);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        wr_last = l;
        @(negedge clk);
        wr_en = 1'b0;
        wr_last = 1'b0;
    endtask

    task automatic add_exp(input int len, input int kind);
        exp_start[exp_n] = exp_top;
        exp_len[exp_n] = len;
        for (int i = 0; i < len; i++) begin
            exp_mem[exp_top] = gen(kind, i);
            exp_top++;
        end
        exp_n++;
    endtask

    task automatic send_frame(input int len, input int kind);
        int base;
        base = exp_top;
        add_exp(len, kind);
        for (int i = 0; i < len; i++) write_byte(exp_mem[base+i], i == len - 1);
    endtask

    task automatic wait_rx(input int target);
        for (int t = 0; t < 30000 && rx_idx < target; t++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", rx_idx, exp_n);
            summary();
            $finish;
        end
    end

    initial begin
        int ff_idx, ab0, rx0, id0, big_idx;
        ff_idx = -1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_empty == 1'b1, "R1", st_empty, 1);
        chk(st_full == 1'b0 && st_not_full == 1'b1, "R1", {st_full, st_not_full}, 1);
        chk(st_half == 1'b0, "R1", st_half, 0);
        chk(st_underrun == 1'b0 && st_msg_end == 1'b0, "R1", {st_underrun, st_msg_end}, 0);
        chk(irq == 1'b0 && tx_bit == 1'b1, "R1", {irq, tx_bit}, 1);

        // R2 idle flags
        en_mode = 1;
        repeat (200) @(negedge clk);
        chk(idle_flags >= 20, "R2", idle_flags, 20);
        chk(rx_idx == 0 && aborts == 0, "R2", rx_idx + aborts, 0);

        // R5 R6 R7 frames under three strobe patterns
        for (int m = 1; m <= 3; m++) begin
            en_mode = m;
            send_frame(1, 2);
            if (ff_idx < 0) ff_idx = exp_n;
            send_frame(2, 0);
            send_frame(5, 1);
            send_frame(7, 3);
            send_frame(16, 4);
            send_frame(4, 0);
            wait_rx(exp_n);
            repeat (60) @(negedge clk);
            chk(rx_idx == exp_n, "R5", rx_idx, exp_n);
            chk(st_underrun == 1'b0 && aborts == 0, "R8", aborts, 0);
        end
        chk(rx_good[ff_idx] == 1'b1, "R7", rx_good[ff_idx], 1);
        chk(rx_good[ff_idx+1] == 1'b1, "R7", rx_good[ff_idx+1], 1);

        // R9 R10 message-end event
        chk(st_msg_end == 1'b1, "R9", st_msg_end, 1);
        ie_end = 1'b1;
        #1;
        chk(irq == 1'b1, "R10", irq, 1);
        pulse_clr();
        chk(st_msg_end == 1'b0 && irq == 1'b0, "R9", {st_msg_end, irq}, 0);
        ie_end = 1'b0;

        // R3 R4 R10 fill with line stalled
        en_mode = 0;
        repeat (10) @(negedge clk);
        big_idx = exp_n;
        add_exp(64, 2);
        ie_half = 1'b1;
        for (int i = 0; i < 31; i++) write_byte(exp_mem[exp_start[big_idx]+i], 1'b0);
        chk(st_half == 1'b0, "R4", st_half, 0);
        chk(irq == 1'b1, "R10", irq, 1);
        write_byte(exp_mem[exp_start[big_idx]+31], 1'b0);
        chk(st_half == 1'b1, "R4", st_half, 1);
        chk(irq == 1'b0, "R10", irq, 0);
        ie_half = 1'b0;
        ie_nf = 1'b1;
        for (int i = 32; i < 63; i++) write_byte(exp_mem[exp_start[big_idx]+i], 1'b0);
        chk(st_full == 1'b0 && st_not_full == 1'b1 && irq == 1'b1, "R3", {st_full, st_not_full, irq}, 3);
        write_byte(exp_mem[exp_start[big_idx]+63], 1'b1);
        chk(st_full == 1'b1 && st_not_full == 1'b0, "R3", {st_full, st_not_full}, 2);
        chk(irq == 1'b0, "R10", irq, 0);
        ie_nf = 1'b0;
        write_byte(8'h55, 1'b1);
        chk(st_full == 1'b1, "R3", st_full, 1);
        rx0 = rx_idx;
        en_mode = 1;
        wait_rx(exp_n);
        repeat (300) @(negedge clk);
        chk(rx_idx == exp_n && rx_good[big_idx] == 1'b1, "R3", rx_idx, exp_n);
        chk(st_empty == 1'b1 && rx_idx == rx0 + 1, "R3", rx_idx, rx0 + 1);

        // R8 underrun
        pulse_clr();
        ab0 = aborts;
        rx0 = rx_idx;
        id0 = idle_flags;
        write_byte(8'h3C, 1'b0);
        write_byte(8'hFF, 1'b0);
        write_byte(8'h81, 1'b0);
        repeat (250) @(negedge clk);
        chk(st_underrun == 1'b1, "R8", st_underrun, 1);
        chk(aborts == ab0 + 1, "R8", aborts, ab0 + 1);
        chk(rx_idx == rx0, "R8", rx_idx, rx0);
        chk(idle_flags > id0 + 3, "R8", idle_flags, id0 + 4);
        pulse_clr();
        chk(st_underrun == 1'b0, "R9", st_underrun, 0);

        // recovery after abort
        send_frame(3, 4);
        wait_rx(exp_n);
        chk(rx_idx == exp_n && rx_good[exp_n-1] == 1'b1, "R5", rx_idx, exp_n);

        // R11 line held between strobes
        en_mode = 2;
        repeat (100) @(negedge clk);
        chk(tx_viol == 0, "R11", tx_viol, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule